// File: doc/BRIEF.md
# Translation Buffer Entry Manager

This block holds the entries of a 64-entry address translation buffer and gives system software a command port to maintain them. Each entry has two 32-bit words. The tag word carries a valid flag at bit 31 and an 8-bit translation ID in bits 7:0. The data word carries the physical mapping and the permission bits. The lookup logic reads the same storage elsewhere. This block only creates, inspects and removes entries. It also holds the current process-ID register. A tag-word read loads that register as a side effect.

Commands come in on a valid/ready port. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. The block lowers `cmd_ready` only while an invalidate-all sweep runs. A sender that holds `cmd_valid` high during the sweep has its command accepted on the first edge after `cmd_ready` rises again. Read responses have no back-pressure. `rsp_valid` is high for one cycle and the receiver must take the data in that cycle. Every command is privileged. A command taken while `supervisor` is low changes nothing and is reported through a one-cycle fault pulse.

Top module: `tlb_mgmt_port`

## Requirements
- R1: After reset all valid flags read as 0, and `pid`, `busy`, `rsp_valid` and `priv_fault` are 0. `cmd_ready` is 1.
- R2: A supervisor write (`cmd_op`=2'b11) with `cmd_ws`=0 replaces the tag word of entry `cmd_index` with `cmd_wdata`, including the valid flag at bit 31. With `cmd_ws`=1 it replaces the data word. The other word of that entry and all other entries keep their values.
- R3: A supervisor read (`cmd_op`=2'b10) taken at edge N raises `rsp_valid` for exactly the cycle after edge N. `rsp_data` then holds the tag word of entry `cmd_index` when `cmd_ws`=0, or the data word when `cmd_ws`=1.
- R4: A supervisor tag read loads bits 7:0 of the returned tag word into `pid` at the same edge. A data read, a write, or any other command leaves `pid` unchanged.
- R5: Invalidate-all (`cmd_op`=2'b01) clears the valid flag of every entry. All other tag bits and every data word are left as they were.
- R6: Invalidate-all keeps `busy` high and `cmd_ready` low for exactly 64 cycles, starting the cycle after the command is taken. A command presented during that time is not taken and has no effect.
- R7: A command taken with `supervisor`=0 changes no entry and does not change `pid`. It produces no `rsp_valid`, and `priv_fault` is high for exactly the cycle after it is taken.
- R8: Operation code 2'b00 under supervisor mode is a no-op. It changes no state and produces neither `rsp_valid` nor `priv_fault`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can take a command (low during the sweep) |
| cmd_op | input | 2 | 00 no-op, 01 invalidate-all, 10 read, 11 write |
| cmd_index | input | 6 | Entry index 0..63 |
| cmd_ws | input | 1 | Word select: 0 tag word, 1 data word |
| cmd_wdata | input | 32 | Write value |
| supervisor | input | 1 | Privileged mode of the issuer |
| rsp_valid | output | 1 | Read data strobe, one cycle |
| rsp_data | output | 32 | Read data |
| pid | output | 8 | Current process ID |
| busy | output | 1 | Invalidate-all sweep in progress |
| priv_fault | output | 1 | One-cycle pulse for an unprivileged command |

## Verification
The bench first fills all 64 entries with distinct patterns. A word-select or index decode error therefore shows up as a wrong value, not as a coincidental match. It then applies seeded random mixes of tag reads, data reads, writes, no-ops and non-supervisor commands against a reference model. The mix tells a wrong `pid` side effect apart from a wrong read mux, and a fault that still alters state apart from one that only misses its pulse. Directed invalidate-all runs measure the busy window and drive commands into it. Every entry is then read back to show that only bit 31 of each tag word changed.

// File: rtl/tlb_mgmt_pkg.sv
package tlb_mgmt_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_INVAL = 2'b01,
    OP_READ  = 2'b10,
    OP_WRITE = 2'b11
  } tlb_op_e;

  // One-hot strobes for an accepted, privileged command
  typedef struct packed {
    logic inval;
    logic read;
    logic write;
  } cmd_dec_t;

endpackage

// File: rtl/tlb_cmd_ctrl.sv
module tlb_cmd_ctrl
  import tlb_mgmt_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic             supervisor,
  output logic             cmd_ready,
  output logic             busy,
  output cmd_dec_t         dec,
  output logic             sweep_en,
  output logic [IDX_W-1:0] sweep_idx,
  output logic             priv_fault
);

  logic             busy_q;
  logic [IDX_W-1:0] cnt_q;
  logic             fault_q;
  logic             take;
  tlb_op_e          op;

  assign op        = tlb_op_e'(cmd_op);
  assign cmd_ready = ~busy_q;
  assign take      = cmd_valid & ~busy_q;

  always_comb begin
    dec       = '0;
    dec.inval = take & supervisor & (op == OP_INVAL);
    dec.read  = take & supervisor & (op == OP_READ);
    dec.write = take & supervisor & (op == OP_WRITE);
  end

  // Sweep: one entry cleared per clock while busy
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (dec.inval) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == IDX_W'(ENTRIES - 1)) busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) fault_q <= 1'b0;
    else        fault_q <= take & ~supervisor;
  end

  assign busy       = busy_q;
  assign sweep_en   = busy_q;
  assign sweep_idx  = cnt_q;
  assign priv_fault = fault_q;

endmodule

// File: rtl/tlb_entry_store.sv
module tlb_entry_store #(
  parameter int ENTRIES   = 64,
  parameter int WORD_W    = 32,
  parameter int VALID_POS = 31,
  localparam int IDX_W    = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_ws,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              sweep_en,
  input  logic [IDX_W-1:0]  sweep_idx,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_tag,
  output logic [WORD_W-1:0] rd_dat
);

  // Valid flags live in resettable flops; the word storage needs no reset
  logic [ENTRIES-1:0] valid_q;
  logic [WORD_W-1:0]  tag_mem [ENTRIES];
  logic [WORD_W-1:0]  dat_mem [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic hit_w;
    assign hit_w = wr_en && (wr_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n)
        valid_q[i] <= 1'b0;
      else if (sweep_en && (sweep_idx == IDX_W'(i)))
        valid_q[i] <= 1'b0;
      else if (hit_w && !wr_ws)
        valid_q[i] <= wr_data[VALID_POS];
    end

    always_ff @(posedge clk) begin
      if (hit_w && !wr_ws) tag_mem[i] <= wr_data;
      if (hit_w &&  wr_ws) dat_mem[i] <= wr_data;
    end
  end

  always_comb begin
    rd_tag            = tag_mem[rd_idx];
    rd_tag[VALID_POS] = valid_q[rd_idx];
    rd_dat            = dat_mem[rd_idx];
  end

endmodule

// File: rtl/tlb_rd_port.sv
module tlb_rd_port #(
  parameter int WORD_W = 32,
  parameter int TID_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_fire,
  input  logic              rd_ws,
  input  logic [WORD_W-1:0] rd_tag,
  input  logic [WORD_W-1:0] rd_dat,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_data,
  output logic [TID_W-1:0]  pid
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      pid       <= '0;
    end else begin
      rsp_valid <= rd_fire;
      if (rd_fire) begin
        rsp_data <= rd_ws ? rd_dat : rd_tag;
        if (!rd_ws) pid <= rd_tag[TID_W-1:0];
      end
    end
  end

endmodule

// File: rtl/tlb_mgmt_port.sv
module tlb_mgmt_port
  import tlb_mgmt_pkg::*;
#(
  parameter int ENTRIES   = 64,
  parameter int WORD_W    = 32,
  parameter int TID_W     = 8,
  parameter int VALID_POS = 31,
  localparam int IDX_W    = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [IDX_W-1:0]  cmd_index,
  input  logic              cmd_ws,
  input  logic [WORD_W-1:0] cmd_wdata,
  input  logic              supervisor,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_data,
  output logic [TID_W-1:0]  pid,
  output logic              busy,
  output logic              priv_fault
);

  cmd_dec_t          dec;
  logic              sweep_en;
  logic [IDX_W-1:0]  sweep_idx;
  logic [WORD_W-1:0] rd_tag;
  logic [WORD_W-1:0] rd_dat;

  tlb_cmd_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .supervisor (supervisor),
    .cmd_ready  (cmd_ready),
    .busy       (busy),
    .dec        (dec),
    .sweep_en   (sweep_en),
    .sweep_idx  (sweep_idx),
    .priv_fault (priv_fault)
  );

  tlb_entry_store #(
    .ENTRIES   (ENTRIES),
    .WORD_W    (WORD_W),
    .VALID_POS (VALID_POS)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (dec.write),
    .wr_ws     (cmd_ws),
    .wr_idx    (cmd_index),
    .wr_data   (cmd_wdata),
    .sweep_en  (sweep_en),
    .sweep_idx (sweep_idx),
    .rd_idx    (cmd_index),
    .rd_tag    (rd_tag),
    .rd_dat    (rd_dat)
  );

  tlb_rd_port #(.WORD_W(WORD_W), .TID_W(TID_W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_fire   (dec.read),
    .rd_ws     (cmd_ws),
    .rd_tag    (rd_tag),
    .rd_dat    (rd_dat),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .pid       (pid)
  );

endmodule

// File: rtl/tlb_mgmt_chk.sv
module tlb_mgmt_chk #(
  parameter int ENTRIES = 64,
  parameter int TID_W   = 8,
  localparam int CNT_W  = $clog2(ENTRIES) + 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [1:0]       cmd_op,
  input logic             cmd_ws,
  input logic             supervisor,
  input logic             rsp_valid,
  input logic [TID_W-1:0] pid,
  input logic             busy,
  input logic             priv_fault
);

  logic [CNT_W-1:0] run_q;
  logic             take_rd, take_tag, take_bad;

  assign take_rd  = cmd_valid && cmd_ready && supervisor && (cmd_op == 2'b10);
  assign take_tag = take_rd && !cmd_ws;
  assign take_bad = cmd_valid && cmd_ready && !supervisor;

  always_ff @(posedge clk) begin
    if (!rst_n)    run_q <= '0;
    else if (busy) run_q <= run_q + 1'b1;
    else           run_q <= '0;
  end

  AST_RSP_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(take_rd)); // R3

  AST_FAULT_FROM_USER: assert property (@(posedge clk) disable iff (!rst_n)
    priv_fault |-> $past(take_bad)); // R7

  AST_FAULT_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    priv_fault |-> !rsp_valid); // R7

  AST_PID_ONLY_TAG_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (pid != $past(pid)) |-> $past(take_tag)); // R4

  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready); // R6

  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_q == CNT_W'(ENTRIES))); // R6

  AST_BUSY_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= CNT_W'(ENTRIES)); // R6

endmodule

bind tlb_mgmt_port tlb_mgmt_chk #(.ENTRIES(ENTRIES), .TID_W(TID_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_op     (cmd_op),
  .cmd_ws     (cmd_ws),
  .supervisor (supervisor),
  .rsp_valid  (rsp_valid),
  .pid        (pid),
  .busy       (busy),
  .priv_fault (priv_fault)
);

// File: tb/tb_tlb_mgmt_port.sv
`timescale 1ns/1ps
module tb_tlb_mgmt_port;

  localparam int N  = 64;
  localparam int IW = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic        cmd_ready;
  logic [1:0]  cmd_op;
  logic [IW-1:0] cmd_index;
  logic        cmd_ws;
  logic [31:0] cmd_wdata;
  logic        supervisor;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic [7:0]  pid;
  logic        busy;
  logic        priv_fault;

  always #2.5 clk = ~clk;

  tlb_mgmt_port dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_index(cmd_index), .cmd_ws(cmd_ws),
    .cmd_wdata(cmd_wdata), .supervisor(supervisor), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .pid(pid), .busy(busy), .priv_fault(priv_fault)
  );

  int unsigned n_chk  = 0;
  int unsigned n_fail = 0;
  bit          done   = 1'b0;

  logic [31:0] m_tag [N];
  logic [31:0] m_dat [N];
  logic [7:0]  m_pid;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input int idx, input bit ws);
    return ws ? m_dat[idx] : m_tag[idx];
  endfunction

  function automatic logic [31:0] pattern(input int idx, input bit ws);
    return {~ws, 7'(idx), 8'(idx * 3 + 5), 8'hA5 ^ 8'(ws), 8'(idx + 16)};
  endfunction

  // One command; checks quiet outputs before and the response after
  task automatic issue(input logic [1:0] op, input int idx, input bit ws,
                       input logic [31:0] wd, input bit sup, input string req);
    bit rd, wr, bad;
    @(negedge clk);
    chk(!rsp_valid && !priv_fault, "R3/R7 strobe width", {30'd0, rsp_valid, priv_fault}, 32'd0);
    cmd_valid = 1'b1; cmd_op = op; cmd_index = IW'(idx); cmd_ws = ws;
    cmd_wdata = wd; supervisor = sup;
    @(negedge clk);
    cmd_valid = 1'b0;
    bad = !sup;
    rd  = sup && op == 2'b10;
    wr  = sup && op == 2'b11;
    chk(priv_fault == bad, bad ? "R7 fault pulse" : "R8 no fault", {31'd0, priv_fault}, {31'd0, bad});
    chk(rsp_valid == rd, rd ? "R3 rsp_valid" : "R7/R8 no rsp", {31'd0, rsp_valid}, {31'd0, rd});
    if (rd) begin
      chk(rsp_data === exp_word(idx, ws), ws ? "R3 data word" : "R3 tag word", rsp_data, exp_word(idx, ws));
      if (!ws) m_pid = m_tag[idx][7:0];
    end
    if (wr) begin
      if (ws) m_dat[idx] = wd; else m_tag[idx] = wd;
    end
    chk(pid === m_pid, "R4 pid", {24'd0, pid}, {24'd0, m_pid});
  endtask

  task automatic read_all(input string req);
    for (int i = 0; i < N; i++) begin
      issue(2'b10, i, 1'b1, 32'd0, 1'b1, req);
      issue(2'b10, i, 1'b0, 32'd0, 1'b1, req);
    end
  endtask

  task automatic inval_all(input bit poke);
    int cycles = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b01; supervisor = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (busy && cycles < 200) begin
      chk(!cmd_ready, "R6 ready low while busy", {31'd0, cmd_ready}, 32'd0);
      if (poke && cycles == 10) begin
        cmd_valid = 1'b1; cmd_op = 2'b11; cmd_index = 6'd5; cmd_ws = 1'b1;
        cmd_wdata = 32'hDEAD_BEEF; supervisor = 1'b1;
      end
      if (poke && cycles == 12) cmd_valid = 1'b0;
      cycles++;
      @(negedge clk);
    end
    chk(cycles == 64, "R6 busy length", 32'(cycles), 32'd64);
    for (int i = 0; i < N; i++) m_tag[i][31] = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'b00; cmd_index = '0;
    cmd_ws = 1'b0; cmd_wdata = '0; supervisor = 1'b0; m_pid = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pid == 8'd0 && !busy && !rsp_valid && !priv_fault && cmd_ready,
        "R1 reset outputs", {pid, 20'd0, busy, rsp_valid, priv_fault, cmd_ready}, 32'h1);
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 2'b10; cmd_index = IW'(i); cmd_ws = 1'b0; supervisor = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk(rsp_valid && rsp_data[31] == 1'b0, "R1 valid clear after reset", {31'd0, rsp_data[31]}, 32'd0);
      m_pid = rsp_data[7:0];
    end
    for (int i = 0; i < N; i++) begin
      issue(2'b11, i, 1'b0, pattern(i, 1'b0), 1'b1, "R2 fill tag");
      issue(2'b11, i, 1'b1, pattern(i, 1'b1), 1'b1, "R2 fill data");
    end
    read_all("R2 readback");
    // Directed corners
    issue(2'b11, 0,  1'b0, 32'h8000_0077, 1'b0, "R7 user write");
    issue(2'b10, 0,  1'b0, 32'd0, 1'b0, "R7 user read");
    issue(2'b10, 0,  1'b0, 32'd0, 1'b1, "R7 state kept");
    issue(2'b00, 63, 1'b0, 32'h1234_5678, 1'b1, "R8 nop");
    issue(2'b10, 63, 1'b1, 32'd0, 1'b1, "R4 data read keeps pid");
    issue(2'b10, 63, 1'b0, 32'd0, 1'b1, "R4 tag read loads pid");
    issue(2'b01, 0,  1'b0, 32'd0, 1'b0, "R7 user inval");
    chk(!busy, "R7 no sweep for user", {31'd0, busy}, 32'd0);
    read_all("R7 inval blocked");
    inval_all(1'b1);
    read_all("R5 fields kept");
    // Seeded random mix
    for (int k = 0; k < 600; k++) begin
      int unsigned r = $urandom % 20;
      int idx = int'($urandom % N);
      bit ws = 1'($urandom);
      logic [31:0] wd = $urandom;
      if (r < 10)      issue(2'b10, idx, ws, 32'd0, 1'b1, "R3 random read");
      else if (r < 16) issue(2'b11, idx, ws, wd, 1'b1, "R2 random write");
      else if (r < 17) issue(2'b00, idx, ws, wd, 1'b1, "R8 random nop");
      else             issue(2'($urandom), idx, ws, wd, 1'b0, "R7 random user");
    end
    inval_all(1'b0);
    read_all("R5 second sweep");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule